// File: doc/BRIEF.md
# Triple Readback Stream Comparator

This block watches three configuration readback streams. They come from three devices that hold the same configuration and run in lockstep. Each clock cycle can carry one symbol of `SYM_W` bits from each device, and a symbol only counts when all three of its valid strobes are high together. At every aligned position the block votes across the three symbols to find a faulty device. A device that disagrees with the other two is marked alone. When no two symbols agree, all three devices are marked. A one-cycle refresh request then goes to each marked device.

Comparison runs without pause while the devices carry on their normal work. A frame boundary is shown by an end-of-frame strobe on the last beat of the frame. During a frame, a sticky error flag records that some disagreement was seen. A second sticky flag records that the three valid strobes were ever misaligned. A saturating counter for each device holds the number of mismatched positions charged to that device. The end-of-frame beat clears both flags and all three counters.

Top module: `tmr_readback_cmp`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `refresh_o`, `err_o` and `sync_err_o` are 0 and every counter is 0.
- R2: On a beat where all three valids are high and all three symbols are equal, `refresh_o` stays 0 and `err_o` is not set.
- R3: On an aligned beat where exactly one symbol differs from the other two, which agree, only that device's `refresh_o` bit is 1. It is 1 for the single cycle after that beat. Device k uses bit k of `refresh_o` and bits `[k*SYM_W +: SYM_W]` of `rb_data`.
- R4: On an aligned beat where all three symbols differ from one another, all three `refresh_o` bits are 1 in the next cycle.
- R5: `err_o` rises in the cycle after the first mismatching aligned beat of a frame. It then stays 1 until an end-of-frame beat.
- R6: A beat with `frame_end` high clears `err_o`, `sync_err_o` and all counters by the next cycle. A mismatch on that same beat still drives `refresh_o`, but it is neither counted nor flagged.
- R7: A beat on which the valids are not all high is never compared. It produces no refresh request and no count.
- R8: `sync_err_o` is set in the cycle after a beat on which one or two valids are high, and stays set until an end-of-frame beat. A beat with all valids low does not set it.
- R9: The counter of device k, at `miss_cnt_o[k*CNT_W +: CNT_W]`, goes up by one for each aligned beat that marks device k.
- R10: A counter that has reached 2^CNT_W-1 stays there until an end-of-frame beat.
- R11: Aligned beats on consecutive cycles are each compared, with one result per cycle and no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rb_data | input | 3*SYM_W | Readback symbols, device k at slice k |
| rb_valid | input | 3 | Valid strobe per device |
| frame_end | input | 1 | Marks the last beat of a frame |
| refresh_o | output | 3 | One-cycle refresh request per device |
| err_o | output | 1 | Sticky mismatch flag for the current frame |
| sync_err_o | output | 1 | Sticky misaligned-valid flag for the current frame |
| miss_cnt_o | output | 3*CNT_W | Saturating mismatch count per device |

## Verification
The hardest case to reach is a counter pinned at its ceiling. Getting there needs hundreds of mismatching beats in a row, all charged to one device, with no end-of-frame beat in between. The bench produces this by running the 8-bit default counter past 255 in a single long frame that marks only device 0. It then checks that the count holds and that devices 1 and 2 stay at zero. The case with no majority can only happen when symbols are wider than one bit. For this reason the default symbol width is two, so the case can be driven directly.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;
   localparam int unsigned NDEV = 3;

   // Device marking from one vote: bit k set means device k is suspected.
   typedef logic [NDEV-1:0] dev_mask_t;

   function automatic dev_mask_t vote3(input logic eq01, input logic eq02,
                                       input logic eq12);
      dev_mask_t m;
      if (eq01 && eq02)      m = 3'b000;
      else if (eq01)         m = 3'b100;
      else if (eq02)         m = 3'b010;
      else if (eq12)         m = 3'b001;
      else                   m = 3'b111;
      return m;
   endfunction
endpackage

// File: rtl/tmr_in_stage.sv
module tmr_in_stage #(
   parameter int unsigned SYM_W  = 2,
   parameter bit          REG_IN = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [3*SYM_W-1:0]   d_in,
   input  logic [2:0]           v_in,
   input  logic                 e_in,
   output logic [3*SYM_W-1:0]   d_out,
   output logic [2:0]           v_out,
   output logic                 e_out
);
   generate
      if (REG_IN) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               d_out <= '0;
               v_out <= '0;
               e_out <= 1'b0;
            end else begin
               d_out <= d_in;
               v_out <= v_in;
               e_out <= e_in;
            end
         end
      end else begin : g_pass
         assign d_out = d_in;
         assign v_out = v_in;
         assign e_out = e_in;
      end
   endgenerate
endmodule

// File: rtl/tmr_sym_vote.sv
module tmr_sym_vote
   import tmr_cmp_pkg::*;
#(
   parameter int unsigned SYM_W = 2
) (
   input  logic [3*SYM_W-1:0] sym,
   input  logic               en,
   output dev_mask_t          mark
);
   logic [SYM_W-1:0] s [3];

   generate
      for (genvar k = 0; k < 3; k++) begin : g_split
         assign s[k] = sym[k*SYM_W +: SYM_W];
      end
   endgenerate

   always_comb begin
      mark = '0;
      if (en) mark = vote3(s[0] == s[1], s[0] == s[2], s[1] == s[2]);
   end
endmodule

// File: rtl/tmr_miss_cnt.sv
module tmr_miss_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n || clr)                cnt <= '0;
      else if (inc && cnt != CNT_MAX)   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tmr_readback_cmp.sv
module tmr_readback_cmp
   import tmr_cmp_pkg::*;
#(
   parameter int unsigned SYM_W  = 2,
   parameter int unsigned CNT_W  = 8,
   parameter bit          REG_IN = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [3*SYM_W-1:0]   rb_data,
   input  logic [2:0]           rb_valid,
   input  logic                 frame_end,
   output logic [2:0]           refresh_o,
   output logic                 err_o,
   output logic                 sync_err_o,
   output logic [3*CNT_W-1:0]   miss_cnt_o
);
   localparam int unsigned DATA_W = NDEV * SYM_W;

   generate
      if (SYM_W < 1) begin : g_bad_sym
         $error("tmr_readback_cmp: SYM_W must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("tmr_readback_cmp: CNT_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] s_data;
   logic [2:0]        s_valid;
   logic              s_end;
   logic              aligned, partial;
   dev_mask_t         mark;

   tmr_in_stage #(.SYM_W(SYM_W), .REG_IN(REG_IN)) in_i (
      .clk(clk), .rst_n(rst_n),
      .d_in(rb_data), .v_in(rb_valid), .e_in(frame_end),
      .d_out(s_data), .v_out(s_valid), .e_out(s_end)
   );

   assign aligned = &s_valid;
   assign partial = (|s_valid) && !aligned;

   tmr_sym_vote #(.SYM_W(SYM_W)) vote_i (
      .sym(s_data), .en(aligned), .mark(mark)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         refresh_o  <= '0;
         err_o      <= 1'b0;
         sync_err_o <= 1'b0;
      end else begin
         refresh_o  <= mark;
         err_o      <= s_end ? 1'b0 : (err_o | (|mark));
         sync_err_o <= s_end ? 1'b0 : (sync_err_o | partial);
      end
   end

   generate
      for (genvar k = 0; k < NDEV; k++) begin : g_cnt
         tmr_miss_cnt #(.CNT_W(CNT_W)) cnt_i (
            .clk(clk), .rst_n(rst_n),
            .clr(s_end), .inc(mark[k]),
            .cnt(miss_cnt_o[k*CNT_W +: CNT_W])
         );
      end
   endgenerate
endmodule

// File: rtl/tmr_readback_cmp_chk.sv
module tmr_readback_cmp_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2:0]         s_valid,
   input logic               s_end,
   input logic [2:0]         refresh_o,
   input logic               err_o,
   input logic               sync_err_o,
   input logic [3*CNT_W-1:0] miss_cnt_o
);
   assert_refresh_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_o != 3'b000) |-> $past(s_valid) == 3'b111);

   assert_never_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(refresh_o) != 2);

   assert_err_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> refresh_o != 3'b000);

   assert_frame_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(s_end) |-> (!err_o && !sync_err_o && miss_cnt_o == '0));

   assert_sync_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_err_o) |-> ($past(s_valid) != 3'b000 && $past(s_valid) != 3'b111));

   generate
      for (genvar k = 0; k < 3; k++) begin : g_mono
         assert_cnt_mono_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(s_end) |-> miss_cnt_o[k*CNT_W +: CNT_W] >= $past(miss_cnt_o[k*CNT_W +: CNT_W]));
      end
   endgenerate
endmodule

bind tmr_readback_cmp tmr_readback_cmp_chk #(.CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_end(s_end),
   .refresh_o(refresh_o), .err_o(err_o), .sync_err_o(sync_err_o),
   .miss_cnt_o(miss_cnt_o)
);

// File: tb/tmr_readback_cmp_tb.sv
module tmr_readback_cmp_tb_top;
   localparam int SYM_W = 2;
   localparam int CNT_W = 8;
   localparam time CLK_PERIOD = 10ns;
   localparam int CMAX = (1 << CNT_W) - 1;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [3*SYM_W-1:0] rb_data = '0;
   logic [2:0]         rb_valid = '0;
   logic               frame_end = 1'b0;
   logic [2:0]         refresh_o;
   logic               err_o, sync_err_o;
   logic [3*CNT_W-1:0] miss_cnt_o;

   int checks = 0;
   int errors = 0;
   logic [2:0] exp_ref;
   logic       exp_err = 1'b0, exp_sync = 1'b0;
   int         exp_cnt [3] = '{0, 0, 0};

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_readback_cmp #(.SYM_W(SYM_W), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .rb_data(rb_data), .rb_valid(rb_valid),
      .frame_end(frame_end), .refresh_o(refresh_o), .err_o(err_o),
      .sync_err_o(sync_err_o), .miss_cnt_o(miss_cnt_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk({req, " refresh"}, int'(refresh_o), int'(exp_ref));
      chk({req, " err"}, int'(err_o), int'(exp_err));
      chk({req, " sync"}, int'(sync_err_o), int'(exp_sync));
      for (int k = 0; k < 3; k++)
         chk($sformatf("%s cnt%0d", req, k), int'(miss_cnt_o[k*CNT_W +: CNT_W]), exp_cnt[k]);
   endtask

   // One beat: drive at the falling edge, results appear after the next rising edge.
   task automatic beat(input logic [SYM_W-1:0] a, input logic [SYM_W-1:0] b,
                       input logic [SYM_W-1:0] c, input logic [2:0] v,
                       input logic fe, input string req);
      logic [2:0] m;
      m = 3'b000;
      if (v == 3'b111) begin
         if (a == b && a == c) m = 3'b000;
         else if (a == b)      m = 3'b100;
         else if (a == c)      m = 3'b010;
         else if (b == c)      m = 3'b001;
         else                  m = 3'b111;
      end
      exp_ref  = m;
      exp_err  = fe ? 1'b0 : (exp_err | (|m));
      exp_sync = fe ? 1'b0 : (exp_sync | (v != 3'b000 && v != 3'b111));
      for (int k = 0; k < 3; k++)
         if (fe) exp_cnt[k] = 0;
         else if (m[k] && exp_cnt[k] < CMAX) exp_cnt[k]++;
      rb_data   = {c, b, a};
      rb_valid  = v;
      frame_end = fe;
      @(negedge clk);
      check_all(req);
   endtask

   task automatic t_reset;
      exp_ref = 3'b000;
      repeat (3) @(negedge clk);
      check_all("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after reset");
   endtask

   task automatic t_match;
      beat(2'd1, 2'd1, 2'd1, 3'b111, 1'b0, "R2 equal");
      beat(2'd3, 2'd3, 2'd3, 3'b111, 1'b0, "R2 equal b");
   endtask

   task automatic t_single;
      beat(2'd2, 2'd0, 2'd0, 3'b111, 1'b0, "R3 odd dev0");
      beat(2'd0, 2'd0, 2'd0, 3'b000, 1'b0, "R3 pulse ends R5 err held");
      beat(2'd1, 2'd3, 2'd1, 3'b111, 1'b0, "R3 odd dev1 R9");
      beat(2'd1, 2'd1, 2'd0, 3'b111, 1'b0, "R3 odd dev2 R9");
      beat(2'd0, 2'd0, 2'd0, 3'b111, 1'b1, "R6 clear");
   endtask

   task automatic t_nomaj;
      beat(2'd0, 2'd1, 2'd2, 3'b111, 1'b0, "R4 all differ");
      beat(2'd3, 2'd2, 2'd1, 3'b111, 1'b0, "R4 all differ b");
      beat(2'd0, 2'd0, 2'd0, 3'b000, 1'b1, "R6 clear");
   endtask

   task automatic t_unaligned;
      beat(2'd0, 2'd3, 2'd0, 3'b000, 1'b0, "R7 R8 all low ignored");
      beat(2'd0, 2'd3, 2'd0, 3'b101, 1'b0, "R7 R8 partial");
      beat(2'd0, 2'd0, 2'd0, 3'b000, 1'b0, "R8 sync held");
      beat(2'd2, 2'd0, 2'd1, 3'b011, 1'b0, "R7 partial two");
      beat(2'd0, 2'd0, 2'd0, 3'b000, 1'b1, "R8 R6 clear");
   endtask

   task automatic t_end_same_beat;
      beat(2'd1, 2'd0, 2'd0, 3'b111, 1'b0, "R5 set");
      beat(2'd1, 2'd0, 2'd0, 3'b111, 1'b1, "R6 mismatch on end");
   endtask

   task automatic t_stream;
      for (int i = 0; i < 12; i++)
         beat(2'(i), 2'(i % 3 == 0 ? i + 1 : i), 2'(i), 3'b111, 1'b0, "R11 back-to-back");
      beat(2'd0, 2'd0, 2'd0, 3'b000, 1'b1, "R6 clear");
   endtask

   task automatic t_saturate;
      for (int i = 0; i < CMAX + 6; i++)
         beat(2'd3, 2'd0, 2'd0, 3'b111, 1'b0, "R10 R9 count up");
      chk("R10 saturated dev0", int'(miss_cnt_o[0 +: CNT_W]), CMAX);
      beat(2'd0, 2'd0, 2'd0, 3'b111, 1'b1, "R10 R6 clear");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_match();
      t_single();
      t_nomaj();
      t_unaligned();
      t_end_same_beat();
      t_stream();
      t_saturate();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule